// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This controller sits beside the datapath of a five-stage in-order pipeline with fetch, decode, execute, memory and writeback stages. It does not see any data. It sees only register indices, write enables and a load flag taken from the four pipeline registers, plus a taken-branch indication from the branch unit. From these it decides, in the same cycle, whether the PC and the fetch/decode register advance, whether a bubble enters the decode/execute register, and whether wrongly fetched instructions are squashed.

Two parameters select the build variant. `FWD_EN` picks the operand interlock:
- With a bypass network present, only a load followed directly by a consumer of its result is interlocked.
- Without a bypass network, any pending write to a source register by one of the three older instructions holds decode.

`BR_IN_ID` tells the controller where branches resolve, and this sets how many younger instructions a taken branch kills. A bubble is the datapath's cue to zero the memory-write and register-write controls of the instruction entering execute.

Top module: `hazard_ctrl`

## Requirements
- R1: With `FWD_EN=1`, `idex_bubble_o` is 1 when the decode/execute instruction is a load (`idex_load_i=1`, `idex_we_i=1`) whose destination equals a used, non-zero source of the fetch/decode instruction.
- R2: With `FWD_EN=1`, a load-use dependence costs a single bubble. Once the load has moved to the execute/memory register and a bubble occupies decode/execute (destination 0, write enable 0), the held instruction is no longer stalled.
- R3: A stall without a taken branch gives `pc_we_o=0`, `ifid_we_o=0`, `idex_bubble_o=1`, `ifid_flush_o=0` and `pc_sel_target_o=0`.
- R4: With `FWD_EN=0`, a stall is raised whenever a used, non-zero source of the fetch/decode instruction equals the destination of the decode/execute, execute/memory or memory/writeback instruction.
- R5: Register 0 never creates a dependence, and a destination whose write enable is 0 never creates one either.
- R6: With `BR_IN_ID=0`, a taken branch (`br_taken_i=1`) gives `pc_we_o=1`, `pc_sel_target_o=1`, `ifid_we_o=1`, `ifid_flush_o=1` and `idex_bubble_o=1`, which squashes both younger instructions.
- R7: With `BR_IN_ID=1`, a taken branch gives `pc_we_o=1`, `pc_sel_target_o=1`, `ifid_we_o=1`, `ifid_flush_o=1` and `idex_bubble_o=0`, which squashes only the one instruction behind it.
- R8: A source whose used bit (`ifid_rs1_used_i` or `ifid_rs2_used_i`) is 0 never causes a stall.
- R9: When a taken branch and a stall condition coincide, the branch outcome of R6 or R7 is driven.
- R10: With no hazard and no taken branch, `pc_we_o=1`, `ifid_we_o=1`, and `pc_sel_target_o`, `ifid_flush_o` and `idex_bubble_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ifid_rs1_i | input | REG_AW | First source index of the decode instruction |
| ifid_rs2_i | input | REG_AW | Second source index of the decode instruction |
| ifid_rs1_used_i | input | 1 | First source is read |
| ifid_rs2_used_i | input | 1 | Second source is read |
| idex_rd_i | input | REG_AW | Destination of the execute-stage instruction |
| idex_we_i | input | 1 | Execute-stage instruction writes a register |
| idex_load_i | input | 1 | Execute-stage instruction is a load |
| exmem_rd_i | input | REG_AW | Destination of the memory-stage instruction |
| exmem_we_i | input | 1 | Memory-stage instruction writes a register |
| memwb_rd_i | input | REG_AW | Destination of the writeback-stage instruction |
| memwb_we_i | input | 1 | Writeback-stage instruction writes a register |
| br_taken_i | input | 1 | Branch or jump resolved taken in the resolving stage |
| pc_we_o | output | 1 | PC register update enable |
| pc_sel_target_o | output | 1 | PC loads the branch target instead of the next address |
| ifid_we_o | output | 1 | Fetch/decode register update enable |
| ifid_flush_o | output | 1 | Fetch/decode register loads a nop |
| idex_bubble_o | output | 1 | Decode/execute register receives a nop with writes disabled |

## Verification
All five outputs are combinational, so each result is due in the same cycle as the stage snapshot that causes it. The bench drives each snapshot at the falling edge and pushes the expected vector into the queue. The monitor samples one nanosecond later, well before the next rising edge. The one-bubble property of R2 is checked across two consecutive snapshots, the stalled one and the one that follows. Two instances cover the forwarding/EX-resolve build and the no-forwarding/ID-resolve build from the same stimulus.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef struct packed {
    logic pc_we;
    logic pc_tgt;
    logic ifid_we;
    logic ifid_flush;
    logic idex_bubble;
  } hz_ctl_t;

  localparam int unsigned NUM_SRC   = 2;
  localparam int unsigned NUM_OLDER = 3;
endpackage

// File: rtl/hz_dep_cmp.sv
module hz_dep_cmp #(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic              src_used_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              dst_we_i,
  output logic              hit_o
);
  // write enable 0 behaves as destination 0
  logic [REG_AW-1:0] dst_eff;
  assign dst_eff = dst_we_i ? dst_i : '0;
  assign hit_o   = src_used_i && (src_i != '0) && (dst_eff == src_i);
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic [REG_AW-1:0] rs1_i,
  input  logic [REG_AW-1:0] rs2_i,
  input  logic              rs1_used_i,
  input  logic              rs2_used_i,
  input  logic [REG_AW-1:0] idex_rd_i,
  input  logic              idex_we_i,
  input  logic              idex_load_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_we_i,
  output logic              stall_o
);
  logic [NUM_SRC-1:0][REG_AW-1:0]   src;
  logic [NUM_SRC-1:0]               used;
  logic [NUM_OLDER-1:0][REG_AW-1:0] dst;
  logic [NUM_OLDER-1:0]             dwe;
  logic [NUM_SRC-1:0][NUM_OLDER-1:0] hit;

  assign src  = {rs2_i, rs1_i};
  assign used = {rs2_used_i, rs1_used_i};
  // index 0 is the youngest older stage (ID/EX)
  assign dst  = {memwb_rd_i, exmem_rd_i, idex_rd_i};
  assign dwe  = {memwb_we_i, exmem_we_i, idex_we_i};

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar k = 0; k < NUM_OLDER; k++) begin : g_old
      hz_dep_cmp #(.REG_AW(REG_AW)) u_cmp (
        .src_i      (src[s]),
        .src_used_i (used[s]),
        .dst_i      (dst[k]),
        .dst_we_i   (dwe[k]),
        .hit_o      (hit[s][k])
      );
    end
  end

  logic load_use, raw_any;
  assign load_use = idex_load_i && (hit[0][0] || hit[1][0]);
  assign raw_any  = |hit;
  assign stall_o  = FWD_EN ? load_use : raw_any;
endmodule

// File: rtl/hz_flush_unit.sv
module hz_flush_unit
  import hz_pkg::*;
#(
  parameter bit BR_IN_ID = 1'b0
) (
  input  logic    stall_i,
  input  logic    br_taken_i,
  output hz_ctl_t ctl_o
);
  logic kill_idex;

  if (BR_IN_ID) begin : g_id_resolve
    assign kill_idex = 1'b0;   // branch itself moves on to EX
  end else begin : g_ex_resolve
    assign kill_idex = 1'b1;   // instruction in ID is wrong path
  end

  always_comb begin
    if (br_taken_i) begin
      ctl_o.pc_we       = 1'b1;
      ctl_o.pc_tgt      = 1'b1;
      ctl_o.ifid_we     = 1'b1;
      ctl_o.ifid_flush  = 1'b1;
      ctl_o.idex_bubble = kill_idex;
    end else begin
      ctl_o.pc_we       = !stall_i;
      ctl_o.pc_tgt      = 1'b0;
      ctl_o.ifid_we     = !stall_i;
      ctl_o.ifid_flush  = 1'b0;
      ctl_o.idex_bubble = stall_i;
    end
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW   = 5,
  parameter bit          FWD_EN   = 1'b1,
  parameter bit          BR_IN_ID = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] ifid_rs1_i,
  input  logic [REG_AW-1:0] ifid_rs2_i,
  input  logic              ifid_rs1_used_i,
  input  logic              ifid_rs2_used_i,
  input  logic [REG_AW-1:0] idex_rd_i,
  input  logic              idex_we_i,
  input  logic              idex_load_i,
  input  logic [REG_AW-1:0] exmem_rd_i,
  input  logic              exmem_we_i,
  input  logic [REG_AW-1:0] memwb_rd_i,
  input  logic              memwb_we_i,
  input  logic              br_taken_i,
  output logic              pc_we_o,
  output logic              pc_sel_target_o,
  output logic              ifid_we_o,
  output logic              ifid_flush_o,
  output logic              idex_bubble_o
);
  logic    stall;
  hz_ctl_t ctl;

  hz_stall_unit #(.REG_AW(REG_AW), .FWD_EN(FWD_EN)) u_stall (
    .rs1_i       (ifid_rs1_i),
    .rs2_i       (ifid_rs2_i),
    .rs1_used_i  (ifid_rs1_used_i),
    .rs2_used_i  (ifid_rs2_used_i),
    .idex_rd_i   (idex_rd_i),
    .idex_we_i   (idex_we_i),
    .idex_load_i (idex_load_i),
    .exmem_rd_i  (exmem_rd_i),
    .exmem_we_i  (exmem_we_i),
    .memwb_rd_i  (memwb_rd_i),
    .memwb_we_i  (memwb_we_i),
    .stall_o     (stall)
  );

  hz_flush_unit #(.BR_IN_ID(BR_IN_ID)) u_flush (
    .stall_i    (stall),
    .br_taken_i (br_taken_i),
    .ctl_o      (ctl)
  );

  assign pc_we_o         = ctl.pc_we;
  assign pc_sel_target_o = ctl.pc_tgt;
  assign ifid_we_o       = ctl.ifid_we;
  assign ifid_flush_o    = ctl.ifid_flush;
  assign idex_bubble_o   = ctl.idex_bubble;

  a_r1_load_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (FWD_EN && !br_taken_i && idex_load_i && idex_we_i && ifid_rs1_used_i &&
     ifid_rs1_i != '0 && ifid_rs1_i == idex_rd_i) |-> idex_bubble_o);

  a_r3_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idex_bubble_o && !br_taken_i) |-> (!pc_we_o && !ifid_we_o && !ifid_flush_o));

  a_r5_zero_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_taken_i && ifid_rs1_i == '0 && ifid_rs2_i == '0) |-> (pc_we_o && !idex_bubble_o));

  a_r8_unused_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!br_taken_i && !ifid_rs1_used_i && !ifid_rs2_used_i) |-> (ifid_we_o && !idex_bubble_o));

  a_r9_flush_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_taken_i |-> (pc_we_o && pc_sel_target_o && ifid_flush_o));

  a_r6_ex_kill_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!BR_IN_ID && br_taken_i) |-> idex_bubble_o);

  a_r7_id_kill_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BR_IN_ID && br_taken_i) |-> !idex_bubble_o);
endmodule

// File: tb/hazard_ctrl_test.sv
`timescale 1ns/1ps
module hazard_ctrl_test;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [AW-1:0] rs1, rs2, idrd, exrd, wbrd;
  logic u1, u2, idwe, idld, exwe, wbwe, br;
  logic [4:0] out_a, out_b;

  hazard_ctrl #(.REG_AW(AW), .FWD_EN(1'b1), .BR_IN_ID(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .ifid_rs1_i(rs1), .ifid_rs2_i(rs2), .ifid_rs1_used_i(u1), .ifid_rs2_used_i(u2),
    .idex_rd_i(idrd), .idex_we_i(idwe), .idex_load_i(idld),
    .exmem_rd_i(exrd), .exmem_we_i(exwe), .memwb_rd_i(wbrd), .memwb_we_i(wbwe),
    .br_taken_i(br),
    .pc_we_o(out_a[4]), .pc_sel_target_o(out_a[3]), .ifid_we_o(out_a[2]),
    .ifid_flush_o(out_a[1]), .idex_bubble_o(out_a[0]));

  hazard_ctrl #(.REG_AW(AW), .FWD_EN(1'b0), .BR_IN_ID(1'b1)) uut_nf (
    .clk_i(clk), .rst_ni(rst_n),
    .ifid_rs1_i(rs1), .ifid_rs2_i(rs2), .ifid_rs1_used_i(u1), .ifid_rs2_used_i(u2),
    .idex_rd_i(idrd), .idex_we_i(idwe), .idex_load_i(idld),
    .exmem_rd_i(exrd), .exmem_we_i(exwe), .memwb_rd_i(wbrd), .memwb_we_i(wbwe),
    .br_taken_i(br),
    .pc_we_o(out_b[4]), .pc_sel_target_o(out_b[3]), .ifid_we_o(out_b[2]),
    .ifid_flush_o(out_b[1]), .idex_bubble_o(out_b[0]));

  typedef struct {
    string      tag;
    logic [4:0] exp_a;
    logic [4:0] exp_b;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  event drv_ev;

  function automatic bit dep(logic [AW-1:0] s, logic used, logic [AW-1:0] d, logic we);
    return used && (s != 0) && we && (s == d);
  endfunction

  // expected {pc_we, pc_tgt, ifid_we, ifid_flush, idex_bubble} from R1..R10
  function automatic logic [4:0] expect_vec(bit fwd, bit brid);
    bit st;
    if (fwd)
      st = idld && (dep(rs1, u1, idrd, idwe) || dep(rs2, u2, idrd, idwe));
    else
      st = dep(rs1, u1, idrd, idwe) || dep(rs2, u2, idrd, idwe) ||
           dep(rs1, u1, exrd, exwe) || dep(rs2, u2, exrd, exwe) ||
           dep(rs1, u1, wbrd, wbwe) || dep(rs2, u2, wbrd, wbwe);
    if (br) return {1'b1, 1'b1, 1'b1, 1'b1, !brid};
    return {!st, 1'b0, !st, 1'b0, st};
  endfunction

  task automatic drive(string tag,
                       logic [AW-1:0] a1, logic [AW-1:0] a2, logic x1, logic x2,
                       logic [AW-1:0] d0, logic w0, logic ld,
                       logic [AW-1:0] d1, logic w1,
                       logic [AW-1:0] d2, logic w2, logic b);
    item_t it;
    @(negedge clk);
    rs1 = a1; rs2 = a2; u1 = x1; u2 = x2;
    idrd = d0; idwe = w0; idld = ld;
    exrd = d1; exwe = w1; wbrd = d2; wbwe = w2; br = b;
    it.tag   = tag;
    it.exp_a = expect_vec(1'b1, 1'b0);
    it.exp_b = expect_vec(1'b0, 1'b1);
    q.push_back(it);
    ->drv_ev;
  endtask

  // monitor: samples 1 ns after the falling-edge drive
  initial begin
    forever begin
      item_t it;
      @(drv_ev);
      #1;
      it = q.pop_front();
      checks++;
      if (out_a !== it.exp_a) begin
        errors++;
        $display("FAIL %s fwd/ex build: actual=%b expected=%b", it.tag, out_a, it.exp_a);
      end
      checks++;
      if (out_b !== it.exp_b) begin
        errors++;
        $display("FAIL %s nofwd/id build: actual=%b expected=%b", it.tag, out_b, it.exp_b);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rs1 = 0; rs2 = 0; u1 = 0; u2 = 0; idrd = 0; idwe = 0; idld = 0;
    exrd = 0; exwe = 0; wbrd = 0; wbwe = 0; br = 0;
    // reset state: idle pipeline free-runs (R10)
    drive("R10_reset", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); rst_n = 1'b1;
    drive("R10_independent", 1, 2, 1, 1, 3, 1, 0, 6, 1, 7, 1, 0);
    // back-to-back ALU dependence: forwarded in one build, stalled in the other
    drive("R4_dep_idex",  3, 2, 1, 1, 3, 1, 0, 0, 0, 0, 0, 0);
    drive("R4_dep_exmem", 1, 5, 1, 1, 9, 1, 0, 5, 1, 0, 0, 0);
    drive("R4_dep_memwb", 6, 1, 1, 1, 9, 1, 0, 8, 1, 6, 1, 0);
    // load followed by its use, then the cycle after the bubble
    drive("R1_R3_load_use_rs2", 1, 4, 1, 1, 4, 1, 1, 0, 0, 0, 0, 0);
    drive("R2_after_bubble",    1, 4, 1, 1, 0, 0, 0, 4, 1, 0, 0, 0);
    drive("R1_load_use_rs1",    8, 2, 1, 1, 8, 1, 1, 0, 0, 0, 0, 0);
    drive("R5_reg_zero",        0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 1, 0);
    drive("R5_we_low",          7, 7, 1, 1, 7, 0, 1, 7, 0, 7, 0, 0);
    drive("R8_unused_src",      4, 4, 0, 0, 4, 1, 1, 4, 1, 4, 1, 0);
    drive("R8_one_used",        2, 4, 1, 0, 4, 1, 1, 0, 0, 0, 0, 0);
    // taken beq, then taken beq against a load-use
    drive("R6_R7_taken",        1, 2, 1, 1, 3, 1, 0, 0, 0, 0, 0, 1);
    drive("R9_taken_vs_stall",  4, 2, 1, 1, 4, 1, 1, 4, 1, 4, 1, 1);
    // not-taken beq: normal flow
    drive("R10_not_taken",      1, 2, 1, 1, 3, 1, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule